// File: doc/BRIEF.md
# Priority Transmit Queue Selector

This block decides which of six transmit queues supplies the next frame to the MAC transmitter. Each queue raises a pending flag when the host posts a frame to it. The transmitter signals that it can start a frame by holding `tx_idle_i` high. When no frame is in flight and at least one queue is pending, the selector registers a one-hot grant for the lowest-numbered pending queue. It holds that grant until the transmitter pulses `done_i`.

Queues 2 and 5 are static. A host post loads a frame into a static queue and marks it loaded. After the frame is sent, the queue stays loaded but is no longer pending. A hardware event then re-arms it, with no host access:
- a main-buffer watermark pulse re-arms queue 2, which suits pause frames;
- a host-response timeout pulse re-arms queue 5.

Frame storage, framing and the timers that produce the events are outside this block.

The grant side works as a stream handshake:
- `grant_vld_o` is the valid signal and `tx_idle_i` acts as ready at the moment of selection.
- While `tx_idle_i` is low, no selection is made and pending queues wait. This is the only back-pressure.
- Once a grant is issued it is owned by the transmitter until `done_i`.

Top module: `txq_prio_sel`

## Requirements
- R1: After reset, `grant_o`, `grant_vld_o` and `pend_o` are all zero and no static queue is loaded.
- R2: A pulse on `post_i[i]` sets bit i of `pend_o` on the next clock edge. Posting to a queue that is already pending has no further effect.
- R3: A selection happens only in a cycle where `grant_vld_o` is low, `tx_idle_i` is high and some bit of `pend_o` is set. The grant is visible after that edge. With `tx_idle_i` low, `grant_vld_o` stays low.
- R4: The selected queue is the lowest index i whose `pend_o[i]` is 1. `grant_o` has only bit i set and `grant_vld_o` is 1.
- R5: While `grant_vld_o` is high and `done_i` is low, `grant_o` keeps its value, even if a lower-numbered queue becomes pending.
- R6: `done_i` high while a grant is active clears the granted queue's pending bit and drops the grant on that edge. No new grant is issued on that same edge.
- R7: After its frame is done, a static queue (index 2 or 5) stays loaded. Non-static queues never become loaded.
- R8: A pulse on `wm_trig_i` sets `pend_o[2]` if queue 2 is loaded. Otherwise it has no effect.
- R9: A pulse on `hto_trig_i` sets `pend_o[5]` if queue 5 is loaded. Otherwise it has no effect.
- R10: If a post or trigger for the granted queue arrives in the same cycle as `done_i`, that queue's pending bit stays set.
- R11: `done_i` while `grant_vld_o` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_i | input | 6 | Host posted a frame to queue i (one-cycle pulse per bit) |
| wm_trig_i | input | 1 | Main-buffer watermark event; re-arms static queue 2 |
| hto_trig_i | input | 1 | Host-response timeout event; re-arms static queue 5 |
| tx_idle_i | input | 1 | Transmitter idle and ready to start a frame |
| done_i | input | 1 | Transmitter finished the granted frame |
| grant_o | output | 6 | One-hot grant of the selected queue |
| grant_vld_o | output | 1 | A grant is active |
| pend_o | output | 6 | Per-queue frame-pending flags |

## Verification
The hardest situation to reach from the ports is re-arming a static queue. The queue must first be posted, granted and completed. Only then can a trigger revive it, and a trigger sent before that point must be shown to do nothing. The stimulus therefore follows that exact order and fires a trigger on either side of the load. A second hard case is a trigger that lands in the same cycle as its own queue's done pulse. The bench gets there by holding queue 5 granted and driving both inputs on one edge. Long random runs then mix posts, events, idle gaps and done pulses, and a cycle-level model tracks every flag.

// File: rtl/txq_sel_pkg.sv
package txq_sel_pkg;
  localparam int QCOUNT_DEF = 6;
  localparam int WM_QUEUE_DEF = 2;
  localparam int HTO_QUEUE_DEF = 5;

  typedef enum logic [0:0] {
    SEL_IDLE = 1'b0,
    SEL_BUSY = 1'b1
  } sel_state_e;
endpackage

// File: rtl/txq_flag_bank.sv
module txq_flag_bank #(
  parameter int QCOUNT = 6,
  parameter logic [QCOUNT-1:0] STATIC_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QCOUNT-1:0] post,
  input  logic [QCOUNT-1:0] trig,
  input  logic [QCOUNT-1:0] clr,
  output logic [QCOUNT-1:0] pend,
  output logic [QCOUNT-1:0] loaded
);
  for (genvar q = 0; q < QCOUNT; q++) begin : g_q
    logic set_q;

    if (STATIC_MASK[q]) begin : g_static
      logic load_r;
      always_ff @(posedge clk) begin
        if (!rst_n) load_r <= 1'b0;
        else if (post[q]) load_r <= 1'b1;
      end
      assign loaded[q] = load_r;
      assign set_q = post[q] | (trig[q] & load_r);
    end else begin : g_plain
      assign loaded[q] = 1'b0;
      assign set_q = post[q];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pend[q] <= 1'b0;
      else pend[q] <= set_q | (pend[q] & ~clr[q]);
    end
  end
endmodule

// File: rtl/txq_lowest_pick.sv
module txq_lowest_pick #(
  parameter int QCOUNT = 6
) (
  input  logic [QCOUNT-1:0] req,
  output logic [QCOUNT-1:0] pick,
  output logic              any
);
  always_comb begin
    pick = '0;
    for (int q = QCOUNT - 1; q >= 0; q--) begin
      if (req[q]) pick = QCOUNT'(1) << q;
    end
    any = |req;
  end
endmodule

// File: rtl/txq_grant_ctl.sv
module txq_grant_ctl
  import txq_sel_pkg::*;
#(
  parameter int QCOUNT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              any_req,
  input  logic [QCOUNT-1:0] pick,
  input  logic              done,
  output logic [QCOUNT-1:0] grant,
  output logic              busy
);
  sel_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SEL_IDLE;
      grant <= '0;
    end else begin
      case (st_q)
        SEL_IDLE: if (ready && any_req) begin
          st_q  <= SEL_BUSY;
          grant <= pick;
        end
        SEL_BUSY: if (done) begin
          st_q  <= SEL_IDLE;
          grant <= '0;
        end
        default: st_q <= SEL_IDLE;
      endcase
    end
  end

  assign busy = (st_q == SEL_BUSY);
endmodule

// File: rtl/txq_prio_sel.sv
module txq_prio_sel
  import txq_sel_pkg::*;
#(
  parameter int QCOUNT = QCOUNT_DEF,
  parameter int WM_QUEUE = WM_QUEUE_DEF,
  parameter int HTO_QUEUE = HTO_QUEUE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QCOUNT-1:0] post_i,
  input  logic              wm_trig_i,
  input  logic              hto_trig_i,
  input  logic              tx_idle_i,
  input  logic              done_i,
  output logic [QCOUNT-1:0] grant_o,
  output logic              grant_vld_o,
  output logic [QCOUNT-1:0] pend_o
);
  localparam logic [QCOUNT-1:0] STATIC_MASK =
    (QCOUNT'(1) << WM_QUEUE) | (QCOUNT'(1) << HTO_QUEUE);

  logic [QCOUNT-1:0] trig_v, clr_v, pick_v, loaded_v;
  logic any_v, busy_v;

  for (genvar q = 0; q < QCOUNT; q++) begin : g_trig
    if (q == WM_QUEUE) begin : g_wm
      assign trig_v[q] = wm_trig_i;
    end else if (q == HTO_QUEUE) begin : g_hto
      assign trig_v[q] = hto_trig_i;
    end else begin : g_none
      assign trig_v[q] = 1'b0;
    end
  end

  assign clr_v = (busy_v && done_i) ? grant_o : '0;

  txq_flag_bank #(.QCOUNT(QCOUNT), .STATIC_MASK(STATIC_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .post(post_i), .trig(trig_v), .clr(clr_v),
    .pend(pend_o), .loaded(loaded_v)
  );

  txq_lowest_pick #(.QCOUNT(QCOUNT)) u_pick (
    .req(pend_o), .pick(pick_v), .any(any_v)
  );

  txq_grant_ctl #(.QCOUNT(QCOUNT)) u_gnt (
    .clk(clk), .rst_n(rst_n), .ready(tx_idle_i), .any_req(any_v),
    .pick(pick_v), .done(done_i), .grant(grant_o), .busy(busy_v)
  );

  assign grant_vld_o = busy_v;
endmodule

// File: rtl/txq_prio_sel_chk.sv
module txq_prio_sel_chk #(
  parameter int QCOUNT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_idle_i,
  input logic              done_i,
  input logic [QCOUNT-1:0] grant_o,
  input logic              grant_vld_o,
  input logic [QCOUNT-1:0] pend_o
);
  // R4
  grant_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (grant_vld_o == (grant_o != '0)));

  // R3
  no_sel_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld_o && !tx_idle_i) |=> !grant_vld_o);

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld_o && tx_idle_i && (pend_o != '0)) |=>
      (grant_o == ($past(pend_o) & (~$past(pend_o) + QCOUNT'(1)))));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !done_i) |=> $stable(grant_o));

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && done_i) |=> !grant_vld_o);

  // R6
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~pend_o) == '0);
endmodule

bind txq_prio_sel txq_prio_sel_chk #(.QCOUNT(QCOUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_idle_i(tx_idle_i), .done_i(done_i),
  .grant_o(grant_o), .grant_vld_o(grant_vld_o), .pend_o(pend_o)
);

// File: tb/txq_prio_sel_tb.sv
module txq_prio_sel_tb;
  localparam int CLK_PER = 10;
  localparam int NQ = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NQ-1:0] post_i = '0;
  logic wm_trig_i = 1'b0, hto_trig_i = 1'b0, tx_idle_i = 1'b0, done_i = 1'b0;
  logic [NQ-1:0] grant_o, pend_o;
  logic grant_vld_o;

  int total = 0, bad = 0, cyc = 0;
  int m_pend[NQ];
  int m_load[NQ];
  int m_gnt = -1;

  always #(CLK_PER/2) clk = ~clk;

  txq_prio_sel u_dut (
    .clk(clk), .rst_n(rst_n), .post_i(post_i), .wm_trig_i(wm_trig_i),
    .hto_trig_i(hto_trig_i), .tx_idle_i(tx_idle_i), .done_i(done_i),
    .grant_o(grant_o), .grant_vld_o(grant_vld_o), .pend_o(pend_o)
  );

  function automatic logic [NQ-1:0] m_pend_vec();
    logic [NQ-1:0] v = '0;
    for (int i = 0; i < NQ; i++) v[i] = (m_pend[i] != 0);
    return v;
  endfunction

  function automatic logic [NQ-1:0] m_gnt_vec();
    return (m_gnt < 0) ? '0 : NQ'(1) << m_gnt;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int clr = (done_i && m_gnt >= 0) ? m_gnt : -1;
    int old_p[NQ];
    for (int i = 0; i < NQ; i++) old_p[i] = m_pend[i];
    for (int i = 0; i < NQ; i++) begin
      int st;
      st = (i == 2 || i == 5) ? 1 : 0;
      if (post_i[i]) m_pend[i] = 1;
      else if ((i == 2 && wm_trig_i && m_load[i] != 0) ||
               (i == 5 && hto_trig_i && m_load[i] != 0)) m_pend[i] = 1;
      else if (i == clr) m_pend[i] = 0;
      if (st != 0 && post_i[i]) m_load[i] = 1;
    end
    if (m_gnt >= 0) begin
      if (done_i) m_gnt = -1;
    end else if (tx_idle_i) begin
      for (int i = NQ - 1; i >= 0; i--) if (old_p[i] != 0) m_gnt = i;
    end
  endtask

  task automatic step(logic [NQ-1:0] p, logic wm, logic ht, logic idl, logic dn);
    post_i = p; wm_trig_i = wm; hto_trig_i = ht; tx_idle_i = idl; done_i = dn;
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R4/R5 model grant", 32'(grant_o), 32'(m_gnt_vec()));
    chk("R2/R6 model pend", 32'(pend_o), 32'(m_pend_vec()));
    post_i = '0; wm_trig_i = 0; hto_trig_i = 0; done_i = 0;
  endtask

  initial begin
    for (int i = 0; i < NQ; i++) begin m_pend[i] = 0; m_load[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset grant", 32'(grant_o), 0);
    chk("R1 reset vld", 32'(grant_vld_o), 0);
    chk("R1 reset pend", 32'(pend_o), 0);
    // R8 R9: triggers before load are ignored
    step('0, 1, 1, 0, 0);
    chk("R8 wm unloaded", 32'(pend_o[2]), 0);
    chk("R9 hto unloaded", 32'(pend_o[5]), 0);
    // R2 and R3: post while transmitter busy
    step(6'b001010, 0, 0, 0, 0);
    chk("R2 post sets pend", 32'(pend_o), 32'h0a);
    step('0, 0, 0, 0, 0);
    chk("R3 no grant unready", 32'(grant_vld_o), 0);
    // R11: done without grant
    step('0, 0, 0, 0, 1);
    chk("R11 done ignored", 32'(pend_o), 32'h0a);
    // R4
    step('0, 0, 0, 1, 0);
    chk("R4 lowest wins", 32'(grant_o), 32'h02);
    // R5: queue 0 posted mid frame
    step(6'b000001, 0, 0, 1, 0);
    step('0, 0, 0, 1, 0);
    chk("R5 grant held", 32'(grant_o), 32'h02);
    // R6
    step('0, 0, 0, 1, 1);
    chk("R6 grant dropped", 32'(grant_vld_o), 0);
    chk("R6 pend cleared", 32'(pend_o), 32'h09);
    step('0, 0, 0, 1, 0);
    chk("R4 next pick q0", 32'(grant_o), 32'h01);
    step('0, 0, 0, 1, 1);
    step('0, 0, 0, 1, 0);
    step('0, 0, 0, 1, 1);
    // R7 R8: load queue 2, send it, re-arm by watermark
    step(6'b000100, 0, 0, 1, 0);
    step('0, 0, 0, 1, 0);
    chk("R4 q2 granted", 32'(grant_o), 32'h04);
    step('0, 0, 0, 0, 1);
    chk("R7 q2 idle after done", 32'(pend_o[2]), 0);
    step('0, 1, 0, 0, 0);
    chk("R8 wm re-arms q2", 32'(pend_o[2]), 1);
    chk("R7 q2 stayed loaded", 32'(pend_o[2]), 1);
    step('0, 0, 0, 1, 0);
    step('0, 0, 0, 0, 1);
    // R9 R10: queue 5
    step(6'b100000, 0, 0, 1, 0);
    step('0, 0, 0, 1, 0);
    chk("R4 q5 granted", 32'(grant_o), 32'h20);
    step('0, 0, 1, 0, 1);
    chk("R10 set beats clear", 32'(pend_o[5]), 1);
    step('0, 0, 0, 1, 0);
    step('0, 0, 0, 0, 1);
    step('0, 0, 1, 0, 0);
    chk("R9 hto re-arms q5", 32'(pend_o[5]), 1);
    // R7: non-static queue not re-armed by events
    step(6'b010000, 0, 0, 0, 0);
    step('0, 0, 0, 1, 0);
    step('0, 0, 0, 1, 1);
    step('0, 1, 1, 0, 0);
    chk("R7 q4 not rearmed", 32'(pend_o[4]), 0);
    for (int k = 0; k < 2000; k++) begin
      logic [NQ-1:0] pr = NQ'($urandom) & NQ'($urandom);
      step(pr, ($urandom % 5) == 0, ($urandom % 7) == 0,
           ($urandom % 3) != 0, ($urandom % 3) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog R1 act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule